// File: doc/BRIEF.md
# Text-Mode VGA Display Controller

This block scans a monochrome character screen out of a 4K-byte video RAM and produces VGA horizontal sync, vertical sync and a one-bit pixel stream. A horizontal counter wraps at the line total and steps a vertical counter that wraps at the frame total. The sync pulses and blanking intervals are decoded from these two counters. The same RAM holds the screen text and the font. The first 3K holds character codes, row by row. The top 1K holds 128 glyphs of 8 bytes each. For every 8-pixel cell the controller makes two reads in sequence: first the character code, then the font byte that the code selects for the current scan line. The font byte is shifted out most significant bit first.

A character row is 10 scan lines tall. Lines 0 to 7 carry the glyph and lines 8 and 9 are blank. This lets 48 rows fill the 480 visible lines. If bit 7 of a code is set, the cell shows an underscore cursor on its two blank lines. A scroll register, written by the CPU with a value from 0 to one less than the row count, rotates which text row appears at the top of the screen. It wraps at the bottom and leaves the RAM contents unchanged. The fetch runs one cell ahead of the beam, so the shifter reloads on every cell boundary with no gap.

Top module: `txtvga_ctrl`

## Requirements
- R1: `hsync_n` is low for exactly H_SYNC pixel clocks in each line of H_TOT = H_VIS+H_FP+H_SYNC+H_BP clocks. Pixel x of a line is the x-th output sample after the line starts. The low interval covers x = H_VIS+H_FP to H_VIS+H_FP+H_SYNC-1.
- R2: `vsync_n` is low for exactly V_SYNC whole lines of each V_TOT-line frame, covering lines V_VIS+V_FP to V_VIS+V_FP+V_SYNC-1. It changes only at the start of a line.
- R3: At a visible text pixel (x, y), with x < COLS*8 and y < ROWS*CELL_LINES, let r = y div CELL_LINES, l = y mod CELL_LINES and l < 8. The pixel equals bit (7 - x mod 8) of the byte at FONT_BASE + code[6:0]*8 + l. Here code is the byte at t*COLS + x div 8, and t is the scrolled text row from R7.
- R4: On cell lines 8 and 9 of a cell whose code has bit 7 clear, all 8 pixels are 0.
- R5: On cell lines 8 and 9 of a cell whose code has bit 7 set, all 8 pixels are 1.
- R6: Every pixel outside the text area is 0. This includes x >= COLS*8, y >= ROWS*CELL_LINES and both sync intervals.
- R7: With scroll value N, screen row r shows text row (r + N) mod ROWS.
- R8: A scroll write whose value is ROWS or more is ignored, and the previous scroll value stays in effect.
- R9: While reset is asserted, `hsync_n` and `vsync_n` are 1 and `pixel` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scroll_wr_en | input | 1 | Write strobe for the scroll register |
| scroll_wr_data | input | $clog2(ROWS) | New scroll value (rows to rotate upward) |
| vram_addr | output | ADDR_W | Read address to the video RAM; the read data is returned one clock later |
| vram_rdata | input | 8 | Read data from the video RAM |
| hsync_n | output | 1 | Horizontal sync, active low |
| vsync_n | output | 1 | Vertical sync, active low |
| pixel | output | 1 | Monochrome pixel, 1 = lit |

## Verification
Two situations are hard to reach from the ports. The first is scroll wraparound combined with a rejected out-of-range write. The second is the cursor underscore on the gap lines. Each needs a full frame of observation and a RAM image that places cursor cells and varied glyph bits where a fault would show. The bench shrinks the timing and text-area parameters so that one whole frame fits in a few thousand clocks. It fills its RAM model with a computed pattern in which every fifth cell carries the cursor bit. It then times each scroll write inside vertical blanking, including values at and above the row count. Every pixel of the following frame is compared with a model built from its own RAM image and the scroll value the table expects.

// File: rtl/txtvga_pkg.sv
package txtvga_pkg;

  localparam int DATA_W     = 8;
  localparam int CURSOR_BIT = 7;

  typedef logic [2:0] phase_t;

  // slots within one 8-clock cell, fetching for the following cell
  localparam phase_t PH_CODE_ADDR = 3'd0;
  localparam phase_t PH_CODE_CAP  = 3'd1;
  localparam phase_t PH_FONT_ADDR = 3'd2;
  localparam phase_t PH_FONT_CAP  = 3'd3;
  localparam phase_t PH_LOAD      = 3'd7;

endpackage

// File: rtl/txtvga_timing.sv
module txtvga_timing
  import txtvga_pkg::*;
#(
  parameter int H_VIS      = 640,
  parameter int H_FP       = 16,
  parameter int H_SYNC     = 96,
  parameter int H_BP       = 48,
  parameter int V_VIS      = 480,
  parameter int V_FP       = 10,
  parameter int V_SYNC     = 2,
  parameter int V_BP       = 28,
  parameter int COLS       = 64,
  parameter int ROWS       = 48,
  parameter int CELL_LINES = 10,
  localparam int H_TOT = H_VIS + H_FP + H_SYNC + H_BP,
  localparam int V_TOT = V_VIS + V_FP + V_SYNC + V_BP,
  localparam int HCW   = $clog2(H_TOT),
  localparam int VCW   = $clog2(V_TOT),
  localparam int CW    = HCW - 3,
  localparam int RW    = $clog2(ROWS),
  localparam int LW    = $clog2(CELL_LINES)
) (
  input  logic          clk,
  input  logic          rst_n,
  output phase_t        phase,
  output logic [CW-1:0] fcol,
  output logic          cell_on,
  output logic [LW-1:0] fline,
  output logic [RW-1:0] frow,
  output logic          hs_act,
  output logic          vs_act
);

  logic [HCW-1:0] hc_q, hc_d;
  logic [VCW-1:0] vc_q, vc_d;
  logic [LW-1:0]  fline_q, fline_d;
  logic [RW-1:0]  frow_q, frow_d;
  logic           fvis_q, fvis_d;
  logic           h_end, v_end, line_adv;

  assign h_end    = (hc_q == HCW'(H_TOT - 1));
  assign v_end    = (vc_q == VCW'(V_TOT - 1));
  // one clock before the last cell of the line: the fetch for column 0
  // of the next line starts in that last cell
  assign line_adv = (hc_q == HCW'(H_TOT - 9));

  always_comb begin
    hc_d = h_end ? '0 : hc_q + 1'b1;
    vc_d = vc_q;
    if (h_end) vc_d = v_end ? '0 : vc_q + 1'b1;
  end

  always_comb begin
    fline_d = fline_q;
    frow_d  = frow_q;
    fvis_d  = fvis_q;
    if (line_adv) begin
      if (v_end) begin
        fline_d = '0;
        frow_d  = '0;
        fvis_d  = 1'b1;
      end else begin
        fvis_d = ((32'(vc_q) + 1) < V_VIS);
        if (fline_q == LW'(CELL_LINES - 1)) begin
          fline_d = '0;
          if (32'(frow_q) != ROWS - 1) frow_d = frow_q + 1'b1;
        end else begin
          fline_d = fline_q + 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hc_q    <= '0;
      vc_q    <= '0;
      fline_q <= '0;
      frow_q  <= '0;
      fvis_q  <= 1'b1;
    end else begin
      hc_q    <= hc_d;
      vc_q    <= vc_d;
      fline_q <= fline_d;
      frow_q  <= frow_d;
      fvis_q  <= fvis_d;
    end
  end

  always_comb begin
    if (hc_q >= HCW'(H_TOT - 8)) fcol = '0;
    else                         fcol = hc_q[HCW-1:3] + 1'b1;
  end

  assign phase   = hc_q[2:0];
  assign cell_on = fvis_q && (32'(fcol) < COLS);
  assign fline   = fline_q;
  assign frow    = frow_q;
  assign hs_act  = (hc_q >= HCW'(H_VIS + H_FP)) && (hc_q < HCW'(H_VIS + H_FP + H_SYNC));
  assign vs_act  = (vc_q >= VCW'(V_VIS + V_FP)) && (vc_q < VCW'(V_VIS + V_FP + V_SYNC));

endmodule

// File: rtl/txtvga_scroll.sv
module txtvga_scroll #(
  parameter int ROWS = 48,
  localparam int RW  = $clog2(ROWS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [RW-1:0] wr_data,
  input  logic [RW-1:0] frow,
  output logic [RW-1:0] scroll,
  output logic [RW-1:0] trow
);

  logic [RW-1:0] scroll_q, scroll_d;
  logic [RW:0]   sum;

  always_comb begin
    scroll_d = scroll_q;
    if (wr_en && (32'(wr_data) < ROWS)) scroll_d = wr_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) scroll_q <= '0;
    else        scroll_q <= scroll_d;
  end

  always_comb begin
    sum = {1'b0, frow} + {1'b0, scroll_q};
    if (32'(sum) >= ROWS) sum = sum - (RW+1)'(ROWS);
  end

  assign trow   = sum[RW-1:0];
  assign scroll = scroll_q;

endmodule

// File: rtl/txtvga_fetch.sv
module txtvga_fetch
  import txtvga_pkg::*;
#(
  parameter int ADDR_W      = 12,
  parameter int COLS        = 64,
  parameter int FONT_BASE   = 3072,
  parameter int GLYPH_LINES = 8,
  parameter int CW          = 7,
  parameter int RW          = 6,
  localparam int GL_W = $clog2(GLYPH_LINES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  phase_t            phase,
  input  logic [CW-1:0]     fcol,
  input  logic [RW-1:0]     trow,
  input  logic [GL_W-1:0]   fline_lo,
  input  logic [DATA_W-1:0] vram_rdata,
  output logic [ADDR_W-1:0] vram_addr,
  output logic [DATA_W-1:0] font_byte,
  output logic              cursor
);

  logic [DATA_W-1:0] code_q, code_d;
  logic [DATA_W-1:0] font_q, font_d;
  logic [ADDR_W-1:0] char_addr, font_addr;

  assign char_addr = ADDR_W'(trow) * ADDR_W'(COLS) + ADDR_W'(fcol);
  assign font_addr = ADDR_W'(FONT_BASE) + ADDR_W'({code_q[DATA_W-2:0], fline_lo});

  // code address in slots 0..1, glyph address from slot 2 on
  assign vram_addr = (phase >= PH_FONT_ADDR) ? font_addr : char_addr;

  always_comb begin
    code_d = (phase == PH_CODE_CAP) ? vram_rdata : code_q;
    font_d = (phase == PH_FONT_CAP) ? vram_rdata : font_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      code_q <= '0;
      font_q <= '0;
    end else begin
      code_q <= code_d;
      font_q <= font_d;
    end
  end

  assign font_byte = font_q;
  assign cursor    = code_q[CURSOR_BIT];

endmodule

// File: rtl/txtvga_shifter.sv
module txtvga_shifter
  import txtvga_pkg::*;
#(
  parameter int GLYPH_LINES = 8,
  parameter int LW          = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  phase_t            phase,
  input  logic              cell_on,
  input  logic [LW-1:0]     fline,
  input  logic [DATA_W-1:0] font_byte,
  input  logic              cursor,
  input  logic              hs_act,
  input  logic              vs_act,
  output logic              pixel,
  output logic              hsync_n,
  output logic              vsync_n
);

  logic [DATA_W-1:0] sh_q, sh_d, load_byte;
  logic              pix_q, hs_n_q, vs_n_q;

  always_comb begin
    if (!cell_on)                                load_byte = '0;
    else if (32'(fline) >= GLYPH_LINES)          load_byte = {DATA_W{cursor}};
    else                                         load_byte = font_byte;
    sh_d = (phase == PH_LOAD) ? load_byte : {sh_q[DATA_W-2:0], 1'b0};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q   <= '0;
      pix_q  <= 1'b0;
      hs_n_q <= 1'b1;
      vs_n_q <= 1'b1;
    end else begin
      sh_q   <= sh_d;
      pix_q  <= sh_q[DATA_W-1];
      hs_n_q <= ~hs_act;
      vs_n_q <= ~vs_act;
    end
  end

  assign pixel   = pix_q;
  assign hsync_n = hs_n_q;
  assign vsync_n = vs_n_q;

endmodule

// File: rtl/txtvga_ctrl.sv
module txtvga_ctrl
  import txtvga_pkg::*;
#(
  parameter int H_VIS       = 640,
  parameter int H_FP        = 16,
  parameter int H_SYNC      = 96,
  parameter int H_BP        = 48,
  parameter int V_VIS       = 480,
  parameter int V_FP        = 10,
  parameter int V_SYNC      = 2,
  parameter int V_BP        = 28,
  parameter int COLS        = 64,
  parameter int ROWS        = 48,
  parameter int CELL_LINES  = 10,
  parameter int GLYPH_LINES = 8,
  parameter int ADDR_W      = 12,
  parameter int FONT_BASE   = 3072,
  localparam int H_TOT = H_VIS + H_FP + H_SYNC + H_BP,
  localparam int HCW   = $clog2(H_TOT),
  localparam int CW    = HCW - 3,
  localparam int RW    = $clog2(ROWS),
  localparam int LW    = $clog2(CELL_LINES),
  localparam int GL_W  = $clog2(GLYPH_LINES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scroll_wr_en,
  input  logic [RW-1:0]     scroll_wr_data,
  output logic [ADDR_W-1:0] vram_addr,
  input  logic [DATA_W-1:0] vram_rdata,
  output logic              hsync_n,
  output logic              vsync_n,
  output logic              pixel
);

  phase_t            phase;
  logic [CW-1:0]     fcol;
  logic              cell_on;
  logic [LW-1:0]     fline;
  logic [RW-1:0]     frow, trow, scroll_q;
  logic              hs_act, vs_act;
  logic [DATA_W-1:0] font_byte;
  logic              cursor;

  txtvga_timing #(
    .H_VIS(H_VIS), .H_FP(H_FP), .H_SYNC(H_SYNC), .H_BP(H_BP),
    .V_VIS(V_VIS), .V_FP(V_FP), .V_SYNC(V_SYNC), .V_BP(V_BP),
    .COLS(COLS), .ROWS(ROWS), .CELL_LINES(CELL_LINES)
  ) u_timing (
    .clk(clk), .rst_n(rst_n), .phase(phase), .fcol(fcol), .cell_on(cell_on),
    .fline(fline), .frow(frow), .hs_act(hs_act), .vs_act(vs_act)
  );

  txtvga_scroll #(.ROWS(ROWS)) u_scroll (
    .clk(clk), .rst_n(rst_n), .wr_en(scroll_wr_en), .wr_data(scroll_wr_data),
    .frow(frow), .scroll(scroll_q), .trow(trow)
  );

  txtvga_fetch #(
    .ADDR_W(ADDR_W), .COLS(COLS), .FONT_BASE(FONT_BASE),
    .GLYPH_LINES(GLYPH_LINES), .CW(CW), .RW(RW)
  ) u_fetch (
    .clk(clk), .rst_n(rst_n), .phase(phase), .fcol(fcol), .trow(trow),
    .fline_lo(fline[GL_W-1:0]), .vram_rdata(vram_rdata),
    .vram_addr(vram_addr), .font_byte(font_byte), .cursor(cursor)
  );

  txtvga_shifter #(.GLYPH_LINES(GLYPH_LINES), .LW(LW)) u_shift (
    .clk(clk), .rst_n(rst_n), .phase(phase), .cell_on(cell_on), .fline(fline),
    .font_byte(font_byte), .cursor(cursor), .hs_act(hs_act), .vs_act(vs_act),
    .pixel(pixel), .hsync_n(hsync_n), .vsync_n(vsync_n)
  );

endmodule

// File: rtl/txtvga_ctrl_chk.sv
module txtvga_ctrl_chk #(
  parameter int H_SYNC = 96,
  parameter int V_SYNC = 2,
  parameter int ROWS   = 48,
  localparam int RW    = $clog2(ROWS)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          hsync_n,
  input logic          vsync_n,
  input logic          pixel,
  input logic          scroll_wr_en,
  input logic [RW-1:0] scroll_wr_data,
  input logic [RW-1:0] scroll_q
);

  logic [15:0] hs_low_cnt;
  logic [15:0] vs_line_cnt;
  logic        hs_prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hs_low_cnt  <= '0;
      vs_line_cnt <= '0;
      hs_prev     <= 1'b1;
    end else begin
      hs_prev    <= hsync_n;
      hs_low_cnt <= hsync_n ? 16'd0 : hs_low_cnt + 16'd1;
      if (vsync_n)                  vs_line_cnt <= '0;
      else if (hs_prev && !hsync_n) vs_line_cnt <= vs_line_cnt + 16'd1;
    end
  end

  AST_HSYNC_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hsync_n) |-> (32'(hs_low_cnt) == H_SYNC)); // R1

  AST_VSYNC_LINES: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(vsync_n) |-> (32'(vs_line_cnt) == V_SYNC)); // R2

  AST_DARK_IN_HSYNC: assert property (@(posedge clk) disable iff (!rst_n)
    !hsync_n |-> !pixel); // R6

  AST_DARK_IN_VSYNC: assert property (@(posedge clk) disable iff (!rst_n)
    !vsync_n |-> !pixel); // R6

  AST_SCROLL_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
    (scroll_wr_en && (32'(scroll_wr_data) < ROWS)) |=> (scroll_q == $past(scroll_wr_data))); // R7

  AST_SCROLL_REJECT: assert property (@(posedge clk) disable iff (!rst_n)
    (scroll_wr_en && (32'(scroll_wr_data) >= ROWS)) |=> $stable(scroll_q)); // R8

endmodule

bind txtvga_ctrl txtvga_ctrl_chk #(.H_SYNC(H_SYNC), .V_SYNC(V_SYNC), .ROWS(ROWS)) u_chk (
  .clk(clk), .rst_n(rst_n), .hsync_n(hsync_n), .vsync_n(vsync_n), .pixel(pixel),
  .scroll_wr_en(scroll_wr_en), .scroll_wr_data(scroll_wr_data), .scroll_q(scroll_q)
);

// File: tb/txtvga_ctrl_test.sv
module txtvga_ctrl_test;

  localparam int TH_VIS = 80, TH_FP = 8, TH_SYNC = 8, TH_BP = 8;
  localparam int TV_VIS = 60, TV_FP = 2, TV_SYNC = 2, TV_BP = 2;
  localparam int TCOLS = 8, TROWS = 6, TCELL = 10, TFONT = 3072;
  localparam int H_TOT = TH_VIS + TH_FP + TH_SYNC + TH_BP;
  localparam int V_TOT = TV_VIS + TV_FP + TV_SYNC + TV_BP;
  localparam int RW = $clog2(TROWS);

  typedef struct packed {
    logic [3:0] wr;
    logic [3:0] exp_s;
    logic [1:0] kind;
  } vec_t;

  // write value, scroll expected afterwards, which requirement it targets
  localparam vec_t VEC [0:5] = '{
    '{4'd0, 4'd0, 2'd0},
    '{4'd1, 4'd1, 2'd1},
    '{4'd5, 4'd5, 2'd1},
    '{4'd7, 4'd5, 2'd2},
    '{4'd6, 4'd5, 2'd2},
    '{4'd3, 4'd3, 2'd1}
  };

  logic          clk, rst_n;
  logic          scroll_wr_en;
  logic [RW-1:0] scroll_wr_data;
  logic [11:0]   vram_addr;
  logic [7:0]    vram_rdata;
  logic          hsync_n, vsync_n, pixel;
  logic [7:0]    mem [0:4095];

  int checks = 0, errors = 0;
  int x = 0, y = 0;
  bit done = 0;

  txtvga_ctrl #(
    .H_VIS(TH_VIS), .H_FP(TH_FP), .H_SYNC(TH_SYNC), .H_BP(TH_BP),
    .V_VIS(TV_VIS), .V_FP(TV_FP), .V_SYNC(TV_SYNC), .V_BP(TV_BP),
    .COLS(TCOLS), .ROWS(TROWS), .CELL_LINES(TCELL), .GLYPH_LINES(8),
    .ADDR_W(12), .FONT_BASE(TFONT)
  ) uut (
    .clk(clk), .rst_n(rst_n), .scroll_wr_en(scroll_wr_en),
    .scroll_wr_data(scroll_wr_data), .vram_addr(vram_addr),
    .vram_rdata(vram_rdata), .hsync_n(hsync_n), .vsync_n(vsync_n), .pixel(pixel)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  always_ff @(posedge clk) vram_rdata <= mem[vram_addr];

  function automatic string kind_tag(input logic [1:0] k);
    case (k)
      2'd0:    return "R3";
      2'd1:    return "R7";
      default: return "R8";
    endcase
  endfunction

  task automatic chk(input bit ok, input string tag, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
    x++;
    if (x == H_TOT) begin
      x = 0;
      y++;
      if (y == V_TOT) y = 0;
    end
  endtask

  // categories: 0 glyph lines, 1 gap lines, 2 cursor lines, 3 outside, 4 hsync, 5 vsync
  function automatic int classify(input int px, input int py, input int s);
    int r, l, code;
    if (px >= TCOLS * 8 || py >= TROWS * TCELL) return 3;
    r = py / TCELL;
    l = py % TCELL;
    code = mem[((r + s) % TROWS) * TCOLS + px / 8];
    if (l < 8) return 0;
    return code[7] ? 2 : 1;
  endfunction

  function automatic bit exp_pix(input int px, input int py, input int s);
    int r, l, code, fb;
    if (px >= TCOLS * 8 || py >= TROWS * TCELL) return 1'b0;
    r = py / TCELL;
    l = py % TCELL;
    code = mem[((r + s) % TROWS) * TCOLS + px / 8];
    if (l >= 8) return code[7];
    fb = mem[TFONT + (code % 128) * 8 + l];
    return fb[7 - (px % 8)];
  endfunction

  task automatic scan_frame(input int s, input string ttag);
    int err [6];
    int fa [6];
    int fe [6];
    int cat;
    bit e, a;
    for (int k = 0; k < 6; k++) begin err[k] = 0; fa[k] = 0; fe[k] = 0; end
    for (int n = 0; n < H_TOT * V_TOT; n++) begin
      cat = classify(x, y, s);
      e = exp_pix(x, y, s);
      a = pixel;
      if (a !== e) begin
        if (err[cat] == 0) begin fa[cat] = int'(a); fe[cat] = int'(e); end
        err[cat]++;
      end
      e = !(x >= TH_VIS + TH_FP && x < TH_VIS + TH_FP + TH_SYNC);
      if (hsync_n !== e) begin
        if (err[4] == 0) begin fa[4] = int'(hsync_n); fe[4] = int'(e); end
        err[4]++;
      end
      e = !(y >= TV_VIS + TV_FP && y < TV_VIS + TV_FP + TV_SYNC);
      if (vsync_n !== e) begin
        if (err[5] == 0) begin fa[5] = int'(vsync_n); fe[5] = int'(e); end
        err[5]++;
      end
      step();
    end
    chk(err[0] == 0, ttag, "glyph pixels (first mismatch)", fa[0], fe[0]);
    chk(err[1] == 0, "R4", "gap line pixels", fa[1], fe[1]);
    chk(err[2] == 0, "R5", "cursor underscore pixels", fa[2], fe[2]);
    chk(err[3] == 0, "R6", "border and blanking pixels", fa[3], fe[3]);
    chk(err[4] == 0, "R1", "hsync level", fa[4], fe[4]);
    chk(err[5] == 0, "R2", "vsync level", fa[5], fe[5]);
  endtask

  initial begin
    for (int i = 0; i < 4096; i++) begin
      if (i < TFONT) mem[i] = 8'(((i * 37 + 5) % 128) + ((i % 5 == 0) ? 128 : 0));
      else           mem[i] = 8'(((i - TFONT) * 73 + 11) ^ ((i - TFONT) >> 3));
    end
    rst_n = 1'b0;
    scroll_wr_en = 1'b0;
    scroll_wr_data = '0;
    repeat (4) @(negedge clk);
    // R9: reset state
    chk(hsync_n === 1'b1, "R9", "hsync_n in reset", int'(hsync_n), 1);
    chk(vsync_n === 1'b1, "R9", "vsync_n in reset", int'(vsync_n), 1);
    chk(pixel === 1'b0, "R9", "pixel in reset", int'(pixel), 0);
    rst_n = 1'b1;

    // lock to the first vsync falling edge: that sample is line VS start, pixel 0
    begin
      bit prev = 1'b1;
      forever begin
        @(negedge clk);
        if (!vsync_n && prev) break;
        prev = vsync_n;
      end
    end
    x = 0;
    y = TV_VIS + TV_FP;

    for (int v = 0; v < 6; v++) begin
      while (!(x == 0 && y == TV_VIS)) step();
      scroll_wr_en = 1'b1;
      scroll_wr_data = VEC[v].wr[RW-1:0];
      step();
      scroll_wr_en = 1'b0;
      while (!(x == 0 && y == 0)) step();
      scan_frame(int'(VEC[v].exp_s), kind_tag(VEC[v].kind));
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog all requirements actual=timeout expected=finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule